// File: doc/BRIEF.md
# Host memory window address translator

This block sits between an external host port and an internal memory bus. It maps a flat host address space onto internal addresses. At the bottom or the top of the host space sits a 256-byte configuration window. Next to it is a chain of data windows, each with its own 128-byte-granular offset. Every data window begins where the last enabled window before it ended. A window's offset is added to the low 16 address bits, and the upper bits pass through unchanged.

The block holds its own window registers. An internal configuration port writes them without restriction. The host can write them through the configuration window, unless a write-protect bit is set. Data crossing a data window has its byte lanes reordered to match the host's byte order. Data-window traffic is blocked while the block is disabled or still locked. An address that hits neither the configuration window nor a data window is reported as a miss.

Register words, at host byte offset = word index × 4:
- Word 0 is the control word. Bit 0 is the enable, bits 2:1 are the lane order, bit 3 puts the configuration window at the top, and bit 4 is write protect.
- Word 2+2k holds the end field of data window k+1 in bits 15:7.
- Word 3+2k holds the offset of data window k+1 in bits 15:7.

Top module: `host_win_xlate`

## Requirements
- R1: With control bit 3 clear, host addresses 0x00–0xFF select the configuration window (win_idx 0, win_hit 0). A host read there returns the register word at index addr[7:2], and a host write updates it at the next clock edge.
- R2: With control bit 3 set, the configuration window is the last 256 bytes of the host range, and the first data window starts at address 0.
- R3: A data window k covers host addresses from its start up to end_field×128−1. An end field of 0 disables the window, which then matches no address.
- R4: With control bit 3 clear, the first data window starts at 0x100. Each later window starts at the end of the nearest enabled window below it, or at the chain base if there is none.
- R5: For a data window hit, int_addr[15:0] = host_addr[15:0] + offset_field×128, taken modulo 2^16. The higher internal bits copy the host address.
- R6: Lane order code 00 passes data unchanged, 01 swaps the bytes within each 16-bit half, and 10 reverses all four bytes. Code 11 behaves as 00. The reordering applies to write data and to read data of data windows.
- R7: While control bit 0 is clear, every access outside the configuration window is ignored: int_rd and int_we stay low, ignored is high, and reads return 0x0BAD0BAD.
- R8: While unlocked is low, data window reads and writes are not forwarded and data window reads return 0. The configuration window stays usable.
- R9: While control bit 4 is set, host writes to window end and offset words leave them unchanged. The internal configuration port still writes them. A host write to the control word never changes bit 4.
- R10: While enabled, an access outside every window forwards nothing and reads 0. It drives miss high for exactly the following cycle.
- R11: After reset all registers are zero, so the block is disabled and every data window matches nothing (win_idx all ones).
- R12: Where the configuration window overlaps a data window, the configuration window wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unlocked | input | 1 | Data windows usable when high |
| cfg_we | input | 1 | Internal register write strobe |
| cfg_widx | input | 6 | Internal register word index |
| cfg_wdata | input | 32 | Internal register write data |
| host_addr | input | HOST_AW | Host byte address |
| host_rd | input | 1 | Host read strobe |
| host_we | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| int_addr | output | INT_AW | Translated internal address |
| int_rd | output | 1 | Forwarded internal read |
| int_we | output | 1 | Forwarded internal write |
| int_wdata | output | 32 | Lane-ordered internal write data |
| int_rdata | input | 32 | Internal read data |
| win_hit | output | 1 | Address decodes to a data window |
| win_idx | output | IDX_W | 0 config, k data window k, all ones none |
| ignored | output | 1 | Access outside the configuration window not forwarded |
| miss | output | 1 | One-cycle pulse after an unmapped access |

## Verification
The bench builds the block with four data windows, a 16-bit host address and a 32-bit internal address. With a 16-bit host space, the top configuration window at 0xFF00 can overlap a data window whose end field reaches 0xFF80, so the priority case can be reached. With 16-bit offsets, the translation wraps into bits observable at the port. Four windows leave room for a disabled window inside the chain, which shows that the next window starts at the end of the last enabled one.

// File: rtl/hwt_pkg.sv
package hwt_pkg;
    localparam int unsigned GRAN_LSB  = 7;
    localparam int unsigned FIELD_W   = 9;
    localparam int unsigned REG_IW    = 6;
    localparam int unsigned END_BASE  = 2;
    localparam logic [31:0] OFF_READ  = 32'h0BAD0BAD;

    typedef enum logic [1:0] {
        LANE_LE   = 2'b00,
        LANE_BE16 = 2'b01,
        LANE_BE32 = 2'b10,
        LANE_RSVD = 2'b11
    } lane_e;

    typedef struct packed {
        logic  wp;
        logic  top;
        lane_e lane;
        logic  en;
    } ctrl_t;
endpackage

// File: rtl/hwt_lane_swap.sv
module hwt_lane_swap
    import hwt_pkg::*;
(
    input  lane_e       lane,
    input  logic [31:0] din,
    output logic [31:0] dout
);
    always_comb begin
        case (lane)
            LANE_BE16: dout = {din[23:16], din[31:24], din[7:0], din[15:8]};
            LANE_BE32: dout = {din[7:0], din[15:8], din[23:16], din[31:24]};
            default:   dout = din;
        endcase
    end
endmodule

// File: rtl/hwt_regs.sv
module hwt_regs
    import hwt_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [REG_IW-1:0]                  cfg_widx,
    input  logic [31:0]                        cfg_wdata,
    input  logic                               host_we,
    input  logic [REG_IW-1:0]                  host_widx,
    input  logic [31:0]                        host_wdata,
    input  logic [REG_IW-1:0]                  rd_idx,
    output logic [31:0]                        rd_data,
    output ctrl_t                              ctrl,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]    win_end,
    output logic [NUM_WIN-1:0][FIELD_W-1:0]    win_off
);
    localparam int unsigned LAST_IDX = END_BASE + 2 * NUM_WIN - 1;

    typedef struct packed {
        ctrl_t                            ctrl;
        logic [NUM_WIN-1:0][FIELD_W-1:0]  ends;
        logic [NUM_WIN-1:0][FIELD_W-1:0]  offs;
    } state_t;

    state_t st_d, st_q;

    logic              wr_en, wr_int;
    logic [REG_IW-1:0] wr_idx;
    logic [31:0]       wr_data;
    logic              unused_bits;

    assign wr_en       = cfg_we | host_we;
    assign wr_int      = cfg_we;
    assign wr_idx      = cfg_we ? cfg_widx : host_widx;
    assign wr_data     = cfg_we ? cfg_wdata : host_wdata;
    assign unused_bits = ^{wr_data[31:16], wr_data[6:5]};

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (wr_idx == '0) begin
                st_d.ctrl = ctrl_t'(wr_data[4:0]);
                if (!wr_int) st_d.ctrl.wp = st_q.ctrl.wp;
            end
            for (int k = 0; k < NUM_WIN; k++) begin
                if (wr_int || !st_q.ctrl.wp) begin
                    if (wr_idx == REG_IW'(END_BASE + 2 * k))
                        st_d.ends[k] = wr_data[GRAN_LSB +: FIELD_W];
                    if (wr_idx == REG_IW'(END_BASE + 2 * k + 1))
                        st_d.offs[k] = wr_data[GRAN_LSB +: FIELD_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_idx == '0) rd_data = 32'(st_q.ctrl);
        for (int k = 0; k < NUM_WIN; k++) begin
            if (rd_idx == REG_IW'(END_BASE + 2 * k))
                rd_data = 32'({st_q.ends[k], 7'b0});
            if (rd_idx == REG_IW'(END_BASE + 2 * k + 1))
                rd_data = 32'({st_q.offs[k], 7'b0});
        end
    end

    assign ctrl    = st_q.ctrl;
    assign win_end = st_q.ends;
    assign win_off = st_q.offs;

    initial begin
        if (LAST_IDX >= (1 << REG_IW)) $error("too many windows for register index");
    end

    // R9: with protection on, only the internal port may move window registers
    p_wp_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.wp && !cfg_we) |=> ($stable(st_q.ends) && $stable(st_q.offs)));

    // R9: host writes never alter the protect bit
    p_wp_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(st_q.ctrl.wp));
endmodule

// File: rtl/hwt_decode.sv
module hwt_decode
    import hwt_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned HOST_AW = 16,
    parameter int unsigned IDX_W   = 3
) (
    input  logic [HOST_AW-1:0]              addr,
    input  logic                            top,
    input  logic [NUM_WIN-1:0][FIELD_W-1:0] win_end,
    input  logic [NUM_WIN-1:0][FIELD_W-1:0] win_off,
    output logic                            cfg_hit,
    output logic                            data_hit,
    output logic [IDX_W-1:0]                win_sel,
    output logic [15:0]                     xlate_lo
);
    localparam logic [IDX_W-1:0] SEL_NONE = '1;

    logic [NUM_WIN:0][HOST_AW-1:0] start;
    logic [NUM_WIN-1:0]            in_win;
    logic [FIELD_W-1:0]            off_sel;

    assign start[0] = top ? '0 : HOST_AW'(256);
    assign cfg_hit  = top ? (&addr[HOST_AW-1:8]) : ~(|addr[HOST_AW-1:8]);

    for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
        logic [HOST_AW-1:0] lim;
        logic               live;
        assign lim          = HOST_AW'({win_end[k], 7'b0});
        assign live         = |win_end[k];
        assign in_win[k]    = live && (addr >= start[k]) && (addr < lim);
        assign start[k + 1] = live ? lim : start[k];
    end

    always_comb begin
        win_sel  = SEL_NONE;
        data_hit = 1'b0;
        off_sel  = '0;
        if (cfg_hit) begin
            win_sel = '0;
        end else begin
            for (int k = NUM_WIN - 1; k >= 0; k--) begin
                if (in_win[k]) begin
                    win_sel  = IDX_W'(k + 1);
                    data_hit = 1'b1;
                    off_sel  = win_off[k];
                end
            end
        end
    end

    assign xlate_lo = addr[15:0] + {off_sel, 7'b0};
endmodule

// File: rtl/host_win_xlate.sv
module host_win_xlate
    import hwt_pkg::*;
#(
    parameter int unsigned NUM_WIN = 4,
    parameter int unsigned HOST_AW = 16,
    parameter int unsigned INT_AW  = 32,
    parameter int unsigned IDX_W   = $clog2(NUM_WIN + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               unlocked,
    input  logic               cfg_we,
    input  logic [5:0]         cfg_widx,
    input  logic [31:0]        cfg_wdata,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rd,
    input  logic               host_we,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata,
    output logic [INT_AW-1:0]  int_addr,
    output logic               int_rd,
    output logic               int_we,
    output logic [31:0]        int_wdata,
    input  logic [31:0]        int_rdata,
    output logic               win_hit,
    output logic [IDX_W-1:0]   win_idx,
    output logic               ignored,
    output logic               miss
);
    typedef struct packed {
        logic miss;
    } state_t;

    state_t st_d, st_q;

    ctrl_t                           ctrl;
    logic [NUM_WIN-1:0][FIELD_W-1:0] win_end, win_off;
    logic [31:0]                     reg_rd, rd_swapped;
    logic                            cfg_hit, data_hit, access, fwd;
    logic [15:0]                     xlate_lo;
    logic [INT_AW-1:0]               addr_ext;

    hwt_regs #(.NUM_WIN(NUM_WIN)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_widx   (cfg_widx),
        .cfg_wdata  (cfg_wdata),
        .host_we    (host_we & cfg_hit),
        .host_widx  (host_addr[7:2]),
        .host_wdata (host_wdata),
        .rd_idx     (host_addr[7:2]),
        .rd_data    (reg_rd),
        .ctrl       (ctrl),
        .win_end    (win_end),
        .win_off    (win_off)
    );

    hwt_decode #(.NUM_WIN(NUM_WIN), .HOST_AW(HOST_AW), .IDX_W(IDX_W)) u_decode (
        .addr     (host_addr),
        .top      (ctrl.top),
        .win_end  (win_end),
        .win_off  (win_off),
        .cfg_hit  (cfg_hit),
        .data_hit (data_hit),
        .win_sel  (win_idx),
        .xlate_lo (xlate_lo)
    );

    hwt_lane_swap u_swap_wr (.lane(ctrl.lane), .din(host_wdata), .dout(int_wdata));
    hwt_lane_swap u_swap_rd (.lane(ctrl.lane), .din(int_rdata),  .dout(rd_swapped));

    assign access  = host_rd | host_we;
    assign fwd     = data_hit & ctrl.en & unlocked;
    assign int_rd  = host_rd & fwd;
    assign int_we  = host_we & fwd;
    assign win_hit = data_hit;
    assign ignored = access & ~cfg_hit & ~fwd;

    always_comb begin
        addr_ext       = INT_AW'(host_addr);
        addr_ext[15:0] = xlate_lo;
    end
    assign int_addr = addr_ext;

    always_comb begin
        if (cfg_hit)       host_rdata = reg_rd;
        else if (!ctrl.en) host_rdata = OFF_READ;
        else if (fwd)      host_rdata = rd_swapped;
        else               host_rdata = '0;
    end

    always_comb begin
        st_d      = st_q;
        st_d.miss = access & ctrl.en & ~cfg_hit & ~data_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign miss = st_q.miss;

    // R7: a disabled block forwards nothing
    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |-> (!int_rd && !int_we));

    // R8: no internal write before unlock
    p_locked_nowrite_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !unlocked |-> !int_we);

    // R4: in low placement no data window reaches below 0x100
    p_chain_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (win_hit && !ctrl.top) |-> (host_addr >= HOST_AW'(256)));

    // R12: configuration window shadows any overlapping data window
    p_cfg_first_r12: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_hit |-> !win_hit);

    // R10: a miss pulse always follows an access
    p_miss_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> $past(host_rd || host_we));
endmodule

// File: tb/host_win_xlate_bench.sv
module host_win_xlate_bench;
    localparam int unsigned HOST_AW = 16;
    localparam int unsigned INT_AW  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              unlocked = 1'b0;
    logic              cfg_we = 1'b0;
    logic [5:0]        cfg_widx = '0;
    logic [31:0]       cfg_wdata = '0;
    logic [HOST_AW-1:0] host_addr = '0;
    logic              host_rd = 1'b0;
    logic              host_we = 1'b0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic [INT_AW-1:0] int_addr;
    logic              int_rd, int_we;
    logic [31:0]       int_wdata;
    logic [31:0]       int_rdata = 32'h11223344;
    logic              win_hit;
    logic [2:0]        win_idx;
    logic              ignored, miss;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    host_win_xlate u_host_win_xlate (
        .clk(clk), .rst_n(rst_n), .unlocked(unlocked),
        .cfg_we(cfg_we), .cfg_widx(cfg_widx), .cfg_wdata(cfg_wdata),
        .host_addr(host_addr), .host_rd(host_rd), .host_we(host_we),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .int_addr(int_addr), .int_rd(int_rd), .int_we(int_we),
        .int_wdata(int_wdata), .int_rdata(int_rdata),
        .win_hit(win_hit), .win_idx(win_idx), .ignored(ignored), .miss(miss)
    );

    typedef struct packed {
        logic [15:0] a;
        logic [2:0]  idx;
        logic        hit;
        logic [31:0] ia;
    } vec_t;

    localparam vec_t VEC [0:8] = '{
        '{16'h0100, 3'd1, 1'b1, 32'h0000_0900},
        '{16'h01FF, 3'd1, 1'b1, 32'h0000_09FF},
        '{16'h0200, 3'd3, 1'b1, 32'h0000_0100},
        '{16'h03FF, 3'd3, 1'b1, 32'h0000_02FF},
        '{16'h0400, 3'd4, 1'b1, 32'h0000_0400},
        '{16'h04FF, 3'd4, 1'b1, 32'h0000_04FF},
        '{16'h0500, 3'd7, 1'b0, 32'h0},
        '{16'h00FF, 3'd0, 1'b0, 32'h0},
        '{16'hFFFF, 3'd7, 1'b0, 32'h0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [5:0] i, input logic [31:0] d);
        cfg_widx = i; cfg_wdata = d; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_we = 1'b1;
        tick();
        host_we = 1'b0;
    endtask

    task automatic host_peek(input logic [15:0] a);
        host_addr = a; host_rd = 1'b1;
        #1;
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R11: reset state
        host_peek(16'h0008);
        check("R11 end reg zero", host_rdata, 32'h0);
        host_peek(16'h0100);
        check("R11 no window", 32'(win_idx), 32'd7);
        check("R11 disabled read", host_rdata, 32'h0BAD0BAD);
        check("R11 miss low", 32'(miss), 32'd0);
        host_rd = 1'b0;

        // setup through internal port, low placement
        unlocked = 1'b1;
        cfg_wr(6'd0, 32'h01);
        cfg_wr(6'd2, 32'h0200);
        cfg_wr(6'd3, 32'h0800);
        cfg_wr(6'd6, 32'h0400);
        cfg_wr(6'd7, 32'hFF00);
        cfg_wr(6'd8, 32'h0500);

        // R1: register read back through configuration window
        host_peek(16'h0008);
        check("R1 cfg read", host_rdata, 32'h0200);
        host_rd = 1'b0;

        // R3 R4 R5: table of window decodes
        foreach (VEC[i]) begin
            host_addr = VEC[i].a;
            #1;
            n_chk++;
            if (win_idx !== VEC[i].idx || win_hit !== VEC[i].hit ||
                (VEC[i].hit && int_addr !== VEC[i].ia)) begin
                n_fail++;
                $display("FAIL R3/R4/R5 addr %h: actual idx %0d hit %0b ia %h expected idx %0d hit %0b ia %h",
                         VEC[i].a, win_idx, win_hit, int_addr, VEC[i].idx, VEC[i].hit, VEC[i].ia);
            end
        end

        // R6: lane orders
        host_peek(16'h0100);
        check("R6 lane 00", host_rdata, 32'h11223344);
        host_rd = 1'b0;
        cfg_wr(6'd0, 32'h03);
        host_peek(16'h0100);
        check("R6 lane 01", host_rdata, 32'h22114433);
        host_rd = 1'b0;
        cfg_wr(6'd0, 32'h05);
        host_peek(16'h0100);
        check("R6 lane 10", host_rdata, 32'h44332211);
        host_rd = 1'b0;
        host_addr = 16'h0100; host_wdata = 32'hA1B2C3D4; host_we = 1'b1; #1;
        check("R6 write lane 10", int_wdata, 32'hD4C3B2A1);
        check("R6 write forwarded", 32'(int_we), 32'd1);
        host_we = 1'b0;
        cfg_wr(6'd0, 32'h07);
        host_peek(16'h0100);
        check("R6 lane 11", host_rdata, 32'h11223344);
        host_rd = 1'b0;

        // R9: write protection
        cfg_wr(6'd0, 32'h11);
        host_wr(16'h0008, 32'h0400);
        host_peek(16'h0008);
        check("R9 protected end", host_rdata, 32'h0200);
        host_rd = 1'b0;
        host_wr(16'h0000, 32'h01);
        host_peek(16'h0000);
        check("R9 wp kept", host_rdata, 32'h11);
        host_rd = 1'b0;
        host_wr(16'h000C, 32'h1000);
        host_peek(16'h000C);
        check("R9 protected offset", host_rdata, 32'h0800);
        host_rd = 1'b0;
        cfg_wr(6'd2, 32'h0280);
        host_peek(16'h0008);
        check("R9 internal write", host_rdata, 32'h0280);
        host_rd = 1'b0;
        cfg_wr(6'd2, 32'h0200);
        cfg_wr(6'd0, 32'h01);
        host_wr(16'h000C, 32'h1000);
        host_peek(16'h000C);
        check("R1 host write unprotected", host_rdata, 32'h1000);
        host_rd = 1'b0;
        host_wr(16'h000C, 32'h0800);

        // R2 R12: top placement
        cfg_wr(6'd0, 32'h09);
        host_peek(16'hFF00);
        check("R2 top cfg idx", 32'(win_idx), 32'd0);
        check("R2 top cfg read", host_rdata, 32'h09);
        host_peek(16'h0000);
        check("R2 first window at 0", 32'(win_idx), 32'd1);
        check("R5 top translate", int_addr, 32'h0800);
        host_rd = 1'b0;
        cfg_wr(6'd8, 32'hFF80);
        host_peek(16'hFF10);
        check("R12 cfg priority", 32'(win_idx), 32'd0);
        host_peek(16'hFEFF);
        check("R12 below cfg", 32'(win_idx), 32'd4);
        host_rd = 1'b0;
        cfg_wr(6'd8, 32'h0500);

        // R8: locked
        cfg_wr(6'd0, 32'h01);
        unlocked = 1'b0;
        host_addr = 16'h0100; host_wdata = 32'h5; host_we = 1'b1; #1;
        check("R8 write blocked", 32'(int_we), 32'd0);
        check("R8 ignored", 32'(ignored), 32'd1);
        host_we = 1'b0;
        host_peek(16'h0100);
        check("R8 read zero", host_rdata, 32'h0);
        check("R8 no int read", 32'(int_rd), 32'd0);
        host_peek(16'h0000);
        check("R8 cfg usable", host_rdata, 32'h01);
        host_rd = 1'b0;
        unlocked = 1'b1;

        // R7: disabled
        cfg_wr(6'd0, 32'h00);
        host_peek(16'h0100);
        check("R7 bad read", host_rdata, 32'h0BAD0BAD);
        check("R7 no int read", 32'(int_rd), 32'd0);
        check("R7 ignored", 32'(ignored), 32'd1);
        host_rd = 1'b0;
        cfg_wr(6'd0, 32'h01);

        // R10: miss pulse
        host_peek(16'h0500);
        check("R10 read zero", host_rdata, 32'h0);
        check("R10 no int read", 32'(int_rd), 32'd0);
        check("R10 miss not yet", 32'(miss), 32'd0);
        tick();
        host_rd = 1'b0;
        #1;
        check("R10 miss pulse", 32'(miss), 32'd1);
        tick();
        #1;
        check("R10 miss ends", 32'(miss), 32'd0);

        finished = 1'b1;
        report();
    end
endmodule